// File: doc/BRIEF.md
# Banked Interrupt Enable and Status Unit

This block keeps one interrupt-enable register and one interrupt-status register for each of several localities (five by default). A single shared level interrupt line is driven from them. An event source presents one-cycle pulses that carry a locality tag and a cause mask. The supported causes are data-available (bit 0), status-valid (bit 1), locality-changed (bit 2) and command-ready (bit 7). A cause is latched into a locality's status only when both that locality's master enable (bit 31 of its enable register) and that cause's enable bit are set. Latching a cause raises the shared line.

Software reaches the registers through a simple write strobe with byte enables and a combinational read port, both addressed by locality and register select. Writes change state only when the writing locality is the one the surrounding logic reports as active. Status bits are cleared by writing ones. The line drops when an accepted status write clears the written locality's last pending cause. The polarity field of the enable register (bits 4:3) is stored and read back for the line's consumer to apply; it resets to the low-level setting (bit 3 set).

Top module: `lirq_unit`

## Requirements
- R1: After reset every locality's enable register reads 0x00000008, every status register reads 0, and the interrupt line is low.
- R2: In the enable register only bit 31, bits 4:3 and cause bits 7, 2, 1, 0 are writable; all other bits always read 0 (writable mask 0x8000009F).
- R3: An enable write changes only the byte lanes whose byte-enable bit is set (wr_be[k] covers bits 8k+7:8k); the other bytes keep their values.
- R4: Enable or status writes (wr_sel 0 = enable, 1 = status) are ignored unless active_vld is 1 and active_loc equals wr_loc.
- R5: An event on a valid locality sets the status bits given by cause & enable[7:0] only if enable bit 31 is set, and the line is high from the next clock edge when at least one bit is set.
- R6: Events whose tag is not below the number of localities are ignored, and cause bits 6:3 never set status bits.
- R7: A granted status write with wr_be[0] set clears each supported status bit (mask 0x87) written as 1; bits written 0 and writes without wr_be[0] leave status unchanged.
- R8: The line falls at the edge of a granted status write that takes the written locality's status from non-zero to zero, even when another locality still holds status; a write that leaves status non-zero, or hits an already-zero status, leaves the line as it was.
- R9: When an event and a status clear reach the same locality in one cycle, the new status is (old & ~cleared) | set, and the line stays high.
- R10: Events and writes to one locality leave the enable and status of every other locality unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_vld | input | 1 | A locality currently owns the interface |
| active_loc | input | LOC_W | Owning locality, meaningful when active_vld is 1 |
| evt_valid | input | 1 | One-cycle event pulse |
| evt_loc | input | LOC_W | Locality tag of the event |
| evt_cause | input | 8 | Cause mask of the event |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | LOC_W | Locality addressed by the write |
| wr_sel | input | 1 | 0 = enable register, 1 = status register |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| rd_loc | input | LOC_W | Locality addressed by the read |
| rd_sel | input | 1 | 0 = enable register, 1 = status register |
| rd_data | output | 32 | Combinational read data, 0 for an invalid locality |
| irq | output | 1 | Shared level interrupt line, high when asserted |

## Verification
The bench builds the unit with its default of five localities, which makes the tag field three bits wide. Tags 5 to 7 are therefore representable, and the bench drives them to show that out-of-range events are dropped. Five banks are enough to keep one locality's status pending while another clears its own, which exposes the shared-line rule. The bench also moves ownership between localities to show that writes from a locality that does not own the interface are refused.

// File: rtl/lirq_pkg.sv
// Shared constants for the banked interrupt unit.
// Assumes a 32-bit enable register and an 8-bit stored status.
package lirq_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned STS_W      = 8;
    localparam int unsigned BE_W       = REG_W / 8;
    localparam int unsigned MASTER_BIT = 31;

    localparam logic [STS_W-1:0] CAUSE_DATA_AVAIL = 8'h01;
    localparam logic [STS_W-1:0] CAUSE_STS_VALID  = 8'h02;
    localparam logic [STS_W-1:0] CAUSE_LOC_CHANGE = 8'h04;
    localparam logic [STS_W-1:0] CAUSE_CMD_READY  = 8'h80;
    localparam logic [STS_W-1:0] CAUSE_SUPPORTED  =
        CAUSE_DATA_AVAIL | CAUSE_STS_VALID | CAUSE_LOC_CHANGE | CAUSE_CMD_READY;

    localparam logic [REG_W-1:0] POLARITY_FIELD = 32'h0000_0018;
    localparam logic [REG_W-1:0] POLARITY_LOW   = 32'h0000_0008;
    localparam logic [REG_W-1:0] EN_WMASK =
        (32'h1 << MASTER_BIT) | POLARITY_FIELD | {24'h0, CAUSE_SUPPORTED};
    localparam logic [REG_W-1:0] EN_RESET = POLARITY_LOW;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/lirq_decode.sv
// Turns the write port, the ownership inputs and the event tag into
// per-locality strobes. Assumes at most one write and one event per cycle.
module lirq_decode #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_W   = $clog2(NUM_LOC + 1)
) (
    input  logic               active_vld,
    input  logic [LOC_W-1:0]   active_loc,
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic               wr_sel,
    input  logic               evt_valid,
    input  logic [LOC_W-1:0]   evt_loc,
    output logic [NUM_LOC-1:0] en_gnt,
    output logic [NUM_LOC-1:0] sts_gnt,
    output logic [NUM_LOC-1:0] evt_hit
);
    import lirq_pkg::*;

    logic owner_wr;

    // A write is honoured only when it comes from the owning locality.
    always_comb owner_wr = wr_en && active_vld && (active_loc == wr_loc);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        // Per-locality strobes; out-of-range tags match no bank.
        always_comb begin
            en_gnt[g]  = owner_wr && (wr_loc == LOC_W'(g)) && (wr_sel == SEL_ENABLE);
            sts_gnt[g] = owner_wr && (wr_loc == LOC_W'(g)) && (wr_sel == SEL_STATUS);
            evt_hit[g] = evt_valid && (evt_loc == LOC_W'(g));
        end
    end
endmodule

// File: rtl/lirq_bank.sv
// One locality's enable and status registers. Applies byte-lane enable
// writes, write-one-to-clear status writes and gated event capture.
// Reports whether it latched a cause and whether a clear emptied it.
module lirq_bank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_gnt,
    input  logic        sts_gnt,
    input  logic        evt_hit,
    input  logic [7:0]  evt_cause,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be,
    output logic [31:0] en_q,
    output logic [7:0]  sts_q,
    output logic        set_any,
    output logic        emptied
);
    import lirq_pkg::*;

    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] en_next;
    logic [STS_W-1:0] set_bits;
    logic [STS_W-1:0] clr_bits;
    logic [STS_W-1:0] sts_next;

    // Expand byte enables into a bit mask.
    always_comb begin
        for (int b = 0; b < BE_W; b++) begin
            lane_mask[b*8 +: 8] = {8{wr_be[b]}};
        end
    end

    // Next enable value: addressed lanes take the writable bits of the data.
    always_comb begin
        en_next = en_q;
        if (en_gnt) begin
            en_next = (en_q & ~lane_mask) | (wr_data & lane_mask & EN_WMASK);
        end
    end

    // Causes admitted by the master enable and the per-cause enables.
    always_comb begin
        set_bits = '0;
        if (evt_hit && en_q[MASTER_BIT]) begin
            set_bits = evt_cause & en_q[STS_W-1:0] & CAUSE_SUPPORTED;
        end
    end

    // Bits cleared by a status write in the lowest byte lane.
    always_comb begin
        clr_bits = '0;
        if (sts_gnt && wr_be[0]) begin
            clr_bits = wr_data[STS_W-1:0] & CAUSE_SUPPORTED;
        end
    end

    // Status update: clear first, then new causes win.
    always_comb sts_next = (sts_q & ~clr_bits) | set_bits;

    // Line-control flags for the shared output.
    always_comb begin
        set_any = |set_bits;
        emptied = (|clr_bits) && (|sts_q) && (sts_next == '0);
    end

    // Register state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= EN_RESET;
            sts_q <= '0;
        end else begin
            en_q  <= en_next;
            sts_q <= sts_next;
        end
    end
endmodule

// File: rtl/lirq_line.sv
// Shared level interrupt line. Raised by any latched cause, lowered when
// a granted clear empties the written locality. Raising wins a tie.
module lirq_line #(
    parameter int unsigned NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] set_vec,
    input  logic [NUM_LOC-1:0] empty_vec,
    output logic               irq
);
    logic irq_next;

    // Priority: set over clear over hold.
    always_comb begin
        irq_next = irq;
        if (|empty_vec) irq_next = 1'b0;
        if (|set_vec)   irq_next = 1'b1;
    end

    // Line register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_next;
    end
endmodule

// File: rtl/lirq_unit.sv
// Top of the banked interrupt unit: decode, one bank per locality,
// the shared line and the read multiplexer. Assumes the owner is
// supplied by surrounding logic and that reads have no side effects.
module lirq_unit #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_W   = $clog2(NUM_LOC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_vld,
    input  logic [LOC_W-1:0] active_loc,
    input  logic             evt_valid,
    input  logic [LOC_W-1:0] evt_loc,
    input  logic [7:0]       evt_cause,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       wr_be,
    input  logic [LOC_W-1:0] rd_loc,
    input  logic             rd_sel,
    output logic [31:0]      rd_data,
    output logic             irq
);
    import lirq_pkg::*;

    logic [NUM_LOC-1:0]       en_gnt;
    logic [NUM_LOC-1:0]       sts_gnt;
    logic [NUM_LOC-1:0]       evt_hit;
    logic [NUM_LOC-1:0]       set_vec;
    logic [NUM_LOC-1:0]       empty_vec;
    logic [REG_W-1:0]         en_arr  [NUM_LOC];
    logic [STS_W-1:0]         sts_arr [NUM_LOC];
    logic [NUM_LOC*REG_W-1:0] en_flat;
    logic [NUM_LOC*STS_W-1:0] sts_flat;

    lirq_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_decode (
        .active_vld (active_vld),
        .active_loc (active_loc),
        .wr_en      (wr_en),
        .wr_loc     (wr_loc),
        .wr_sel     (wr_sel),
        .evt_valid  (evt_valid),
        .evt_loc    (evt_loc),
        .en_gnt     (en_gnt),
        .sts_gnt    (sts_gnt),
        .evt_hit    (evt_hit)
    );

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_bank
        lirq_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_gnt    (en_gnt[g]),
            .sts_gnt   (sts_gnt[g]),
            .evt_hit   (evt_hit[g]),
            .evt_cause (evt_cause),
            .wr_data   (wr_data),
            .wr_be     (wr_be),
            .en_q      (en_arr[g]),
            .sts_q     (sts_arr[g]),
            .set_any   (set_vec[g]),
            .emptied   (empty_vec[g])
        );
        // Flattened views for the checker.
        always_comb begin
            en_flat[g*REG_W +: REG_W]  = en_arr[g];
            sts_flat[g*STS_W +: STS_W] = sts_arr[g];
        end
    end

    lirq_line #(.NUM_LOC(NUM_LOC)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .empty_vec (empty_vec),
        .irq       (irq)
    );

    // Read multiplexer; an out-of-range locality reads as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_loc == LOC_W'(i)) begin
                rd_data = (rd_sel == SEL_STATUS) ? {{(REG_W-STS_W){1'b0}}, sts_arr[i]}
                                                 : en_arr[i];
            end
        end
    end
endmodule

// File: rtl/lirq_unit_chk.sv
// Temporal checks on the banked interrupt unit, bound to every instance.
module lirq_unit_chk #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_W   = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   active_vld,
    input logic [LOC_W-1:0]       active_loc,
    input logic                   evt_valid,
    input logic [LOC_W-1:0]       evt_loc,
    input logic                   wr_en,
    input logic [LOC_W-1:0]       wr_loc,
    input logic                   wr_sel,
    input logic                   irq,
    input logic [NUM_LOC*32-1:0]  en_flat,
    input logic [NUM_LOC*8-1:0]   sts_flat
);
    import lirq_pkg::*;

    AST_EN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat & ~{NUM_LOC{EN_WMASK}}) == '0); // R2
    AST_STS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_flat & ~{NUM_LOC{CAUSE_SUPPORTED}}) == '0); // R6
    AST_EN_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_ENABLE && active_vld && active_loc == wr_loc)
        |=> $stable(en_flat)); // R4
    AST_STS_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && (32'(evt_loc) < NUM_LOC))
        |=> ((sts_flat & ~$past(sts_flat)) == '0)); // R6
    AST_IRQ_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> !$rose(irq)); // R5
    AST_IRQ_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && wr_sel == SEL_STATUS)); // R8
endmodule

bind lirq_unit lirq_unit_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_vld (active_vld),
    .active_loc (active_loc),
    .evt_valid  (evt_valid),
    .evt_loc    (evt_loc),
    .wr_en      (wr_en),
    .wr_loc     (wr_loc),
    .wr_sel     (wr_sel),
    .irq        (irq),
    .en_flat    (en_flat),
    .sts_flat   (sts_flat)
);

// File: tb/lirq_unit_tb.sv
// Directed bench for the banked interrupt unit: one task per scenario.
module lirq_unit_tb;
    localparam int unsigned NUM_LOC = 5;
    localparam int unsigned LOC_W   = 3;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             active_vld = 1'b0;
    logic [LOC_W-1:0] active_loc = '0;
    logic             evt_valid = 1'b0;
    logic [LOC_W-1:0] evt_loc = '0;
    logic [7:0]       evt_cause = '0;
    logic             wr_en = 1'b0;
    logic [LOC_W-1:0] wr_loc = '0;
    logic             wr_sel = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [3:0]       wr_be = '0;
    logic [LOC_W-1:0] rd_loc = '0;
    logic             rd_sel = 1'b0;
    logic [31:0]      rd_data;
    logic             irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    lirq_unit #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .active_vld(active_vld), .active_loc(active_loc),
        .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_cause(evt_cause),
        .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_be(wr_be), .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven at a falling edge, strobes dropped after.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        evt_valid = 1'b0;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        active_vld = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic own(input int loc);
        active_vld = 1'b1;
        active_loc = LOC_W'(loc);
    endtask

    task automatic put_wr(input int loc, input logic sel, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_loc = LOC_W'(loc); wr_sel = sel; wr_data = d; wr_be = be;
    endtask

    task automatic put_evt(input int loc, input logic [7:0] cause);
        evt_valid = 1'b1; evt_loc = LOC_W'(loc); evt_cause = cause;
    endtask

    task automatic rd(input int loc, input logic sel, output logic [31:0] v);
        rd_loc = LOC_W'(loc);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string req, input int loc, input logic sel, input logic [31:0] exp);
        logic [31:0] v;
        rd(loc, sel, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        reset_dut();
        for (int i = 0; i < NUM_LOC; i++) begin
            expect_reg("R1 enable reset", i, 1'b0, 32'h0000_0008);
            expect_reg("R1 status reset", i, 1'b1, 32'h0);
        end
        check("R1 line reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_en_mask();
        reset_dut();
        own(1);
        put_wr(1, 1'b0, 32'hFFFF_FFFF, 4'hF); tick();
        expect_reg("R2 writable mask", 1, 1'b0, 32'h8000_009F);
        expect_reg("R10 neighbour enable", 2, 1'b0, 32'h0000_0008);
    endtask

    task automatic t_byte_lane();
        reset_dut();
        own(1);
        put_wr(1, 1'b0, 32'hFFFF_FFFF, 4'hF); tick();
        put_wr(1, 1'b0, 32'h0000_0000, 4'b0001); tick();
        expect_reg("R3 low lane only", 1, 1'b0, 32'h8000_0000);
        put_wr(1, 1'b0, 32'h0000_0000, 4'b1000); tick();
        put_wr(1, 1'b0, 32'hFFFF_FFFF, 4'b0001); tick();
        expect_reg("R3 lane mix", 1, 1'b0, 32'h0000_009F);
    endtask

    task automatic t_owner();
        reset_dut();
        own(2);
        put_wr(2, 1'b0, 32'h8000_0087, 4'hF); tick();
        put_evt(2, 8'h01); tick();
        check("R5 line after event", {31'h0, irq}, 32'h1);
        own(1);
        put_wr(2, 1'b1, 32'h0000_00FF, 4'hF); tick();
        expect_reg("R4 status write from non-owner", 2, 1'b1, 32'h01);
        check("R4 line kept", {31'h0, irq}, 32'h1);
        put_wr(2, 1'b0, 32'h0, 4'hF); tick();
        expect_reg("R4 enable write from non-owner", 2, 1'b0, 32'h8000_0087);
        active_vld = 1'b0;
        put_wr(1, 1'b0, 32'hFFFF_FFFF, 4'hF); tick();
        expect_reg("R4 write with no owner", 1, 1'b0, 32'h0000_0008);
    endtask

    task automatic t_event_gate();
        reset_dut();
        own(0);
        put_wr(0, 1'b0, 32'h0000_0087, 4'hF); tick();
        put_evt(0, 8'h87); tick();
        expect_reg("R5 master off", 0, 1'b1, 32'h0);
        check("R5 line low master off", {31'h0, irq}, 32'h0);
        put_wr(0, 1'b0, 32'h8000_0002, 4'hF); tick();
        put_evt(0, 8'h87); tick();
        expect_reg("R5 cause gated", 0, 1'b1, 32'h02);
        check("R5 line high", {31'h0, irq}, 32'h1);
        put_evt(3, 8'h87); tick();
        expect_reg("R10 other bank untouched", 3, 1'b1, 32'h0);
        expect_reg("R10 owner status kept", 0, 1'b1, 32'h02);
    endtask

    task automatic t_invalid();
        reset_dut();
        own(0);
        put_wr(0, 1'b0, 32'h8000_00FF, 4'hF); tick();
        put_evt(5, 8'hFF); tick();
        put_evt(7, 8'hFF); tick();
        for (int i = 0; i < NUM_LOC; i++) expect_reg("R6 bad tag", i, 1'b1, 32'h0);
        check("R6 line after bad tag", {31'h0, irq}, 32'h0);
        put_evt(0, 8'h78); tick();
        expect_reg("R6 unsupported cause", 0, 1'b1, 32'h0);
        check("R6 line after unsupported cause", {31'h0, irq}, 32'h0);
        put_evt(0, 8'hFF); tick();
        expect_reg("R6 supported only", 0, 1'b1, 32'h87);
    endtask

    task automatic t_w1c();
        reset_dut();
        own(0);
        put_wr(0, 1'b0, 32'h8000_0087, 4'hF); tick();
        put_evt(0, 8'h87); tick();
        put_wr(0, 1'b1, 32'h0000_0001, 4'b0001); tick();
        expect_reg("R7 single clear", 0, 1'b1, 32'h86);
        check("R8 line held while pending", {31'h0, irq}, 32'h1);
        put_wr(0, 1'b1, 32'h0000_FFFF, 4'b0010); tick();
        expect_reg("R7 lane 0 not enabled", 0, 1'b1, 32'h86);
        put_wr(0, 1'b1, 32'h0000_0086, 4'hF); tick();
        expect_reg("R7 full clear", 0, 1'b1, 32'h0);
        check("R8 line dropped", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_shared();
        reset_dut();
        own(0); put_wr(0, 1'b0, 32'h8000_0001, 4'hF); tick();
        own(3); put_wr(3, 1'b0, 32'h8000_0001, 4'hF); tick();
        put_evt(3, 8'h01); tick();
        own(0); put_evt(0, 8'h01); tick();
        expect_reg("R10 bank 3 pending", 3, 1'b1, 32'h01);
        put_wr(0, 1'b1, 32'h1, 4'h1); tick();
        check("R8 drop with other pending", {31'h0, irq}, 32'h0);
        expect_reg("R10 bank 3 kept", 3, 1'b1, 32'h01);
        put_evt(3, 8'h01); tick();
        put_wr(0, 1'b1, 32'h1, 4'h1); tick();
        check("R8 clear of empty status", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_collide();
        reset_dut();
        own(0);
        put_wr(0, 1'b0, 32'h8000_0087, 4'hF); tick();
        put_evt(0, 8'h01); tick();
        put_wr(0, 1'b1, 32'h01, 4'h1); put_evt(0, 8'h80); tick();
        expect_reg("R9 clear and set", 0, 1'b1, 32'h80);
        check("R9 line stays", {31'h0, irq}, 32'h1);
        put_wr(0, 1'b1, 32'h80, 4'h1); put_evt(0, 8'h80); tick();
        expect_reg("R9 same bit", 0, 1'b1, 32'h80);
        check("R9 line same bit", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_en_mask();
        t_byte_lane();
        t_owner();
        t_event_gate();
        t_invalid();
        t_w1c();
        t_shared();
        t_collide();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule